// File: doc/BRIEF.md
# Hot-Swap Overcurrent and Power-Limit Detector

This block watches a hot-swap pass transistor through two digitized samples: the drain current and the drain-source voltage. On every valid sample it compares the current against an effective current-limit threshold and the product of current and voltage against a programmed power threshold. It also compares the current against a fast-trip level, which is a selectable multiple (1.8x or 3.6x) of the current-limit threshold. From these comparisons it drives three outputs:
- a limiting-active flag, which starts the external fault timer;
- a strong gate pull-down request while the fast trip is engaged;
- sticky status bits, with an alert output that a mask can suppress.

The effective threshold and the trip multiple come from pin-strap inputs, and a setup word can override each one separately. A three-state machine holds the operating state: `ST_NORMAL`, `ST_LIMIT` and `ST_TRIP`. It has five transitions:
- `T_ENGAGE` (ST_NORMAL to ST_LIMIT): the current-limit or power-limit compare hits.
- `T_DISENGAGE` (ST_LIMIT to ST_NORMAL): both compares clear.
- `T_BREAK` (ST_NORMAL or ST_LIMIT to ST_TRIP): the fast-trip compare hits.
- `T_RELEASE_LIMIT` (ST_TRIP to ST_LIMIT): the current drops below the current-limit threshold while the power compare still hits.
- `T_RELEASE_IDLE` (ST_TRIP to ST_NORMAL): the current drops below the current-limit threshold and the power compare is clear.

The state register, the limit flags and the status bits all advance only on clock edges where `smp_valid` is high.

Top module: `hsw_limit_detect`

## Requirements
- R1: After reset, `limit_active`, `gate_pulldown`, `ilim_active`, `plim_active`, `status` and `alert` are all 0.
- R2: `ilim_active` takes the value of (current >= effective threshold) one clock after a valid sample.
- R3: `plim_active` takes the value of (current × voltage >= `pwr_lim`) one clock after a valid sample. The product is full width.
- R4: The fast trip fires when 5×current > 9×threshold if the effective ratio select is 0 (1.8x), or when 5×current > 18×threshold if it is 1 (3.6x). A trip sets `gate_pulldown` one clock after the sample.
- R5: Once tripped, `gate_pulldown` stays high while the current is at or above the current-limit threshold. On the first valid sample below that threshold it drops. The state then moves to ST_LIMIT if the power compare hits, and to ST_NORMAL otherwise.
- R6: `limit_active` is high exactly when the state is ST_LIMIT or ST_TRIP. In ST_LIMIT, at least one of `ilim_active` and `plim_active` is high.
- R7: The effective threshold is `setup_ilim` when `setup_ilim_ovr` is 1, and `strap_ilim` otherwise. The effective ratio select is `setup_ratio_hi` when `setup_ratio_ovr` is 1, and `strap_ratio_hi` otherwise.
- R8: `status` bit 0 (current-limit), bit 1 (power-limit) and bit 2 (fast trip) set on a valid sample whose compare hits. They stay set until a `status_clr` pulse. When a set and a clear land on the same edge, the set wins.
- R9: `alert` is high when any status bit is set whose `alert_mask` bit (same position) is 0. Masking a bit does not stop it from being recorded in `status`.
- R10: A clock edge with `smp_valid` low changes none of the limit flags, `gate_pulldown` or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe; the inputs below are evaluated when high |
| i_meas | input | IW | Drain current sample |
| v_ds | input | VW | Drain-source voltage sample |
| strap_ilim | input | IW | Pin-strap current-limit threshold |
| strap_ratio_hi | input | 1 | Pin-strap trip multiple: 0 = 1.8x, 1 = 3.6x |
| setup_ilim_ovr | input | 1 | Use setup_ilim instead of the strap threshold |
| setup_ilim | input | IW | Override current-limit threshold |
| setup_ratio_ovr | input | 1 | Use setup_ratio_hi instead of the strap ratio |
| setup_ratio_hi | input | 1 | Override trip multiple select |
| pwr_lim | input | IW+VW | Power-limit threshold, in current×voltage units |
| alert_mask | input | 3 | Per-status-bit alert suppression |
| status_clr | input | 1 | Pulse that clears all status bits |
| limit_active | output | 1 | Any limiting or trip in progress (fault timer run) |
| gate_pulldown | output | 1 | Strong gate pull-down request |
| ilim_active | output | 1 | Current-limit compare result |
| plim_active | output | 1 | Power-limit compare result |
| status | output | 3 | Sticky events: bit0 current, bit1 power, bit2 trip |
| alert | output | 1 | OR of unmasked status bits |

## Verification
The assertions check several relations on every cycle:
- a pull-down request always comes with limit-active and with the current-limit flag (the hysteresis invariant);
- limiting without a trip always has a cause;
- idle edges freeze the flags;
- status bits never drop without a clear;
- an alert never shows without a status bit;
- every trip is logged.

The exact compare boundaries can only be shown by the bench scenarios: equality at the current limit, 5×current equal to or one step above the trip level at both multiples, and the power product one unit below or at the threshold. The same holds for the override muxing, the release path chosen by the power compare, and set-over-clear priority.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_LIMIT  = 2'd1,
        ST_TRIP   = 2'd2
    } lim_state_e;

    localparam int NUM_EVT    = 3;
    localparam int EVT_ILIM   = 0;
    localparam int EVT_PLIM   = 1;
    localparam int EVT_TRIP   = 2;

    // Trip level factors: 1.8x = 9/5, 3.6x = 18/5
    localparam int TRIP_DEN   = 5;
    localparam int TRIP_NUM   = 9;
    localparam int TRIP_GUARD = 5;   // extra bits for x18 with margin

endpackage

// File: rtl/hsw_cfg_sel.sv
module hsw_cfg_sel #(
    parameter int IW = 12
) (
    input  logic [IW-1:0] strap_ilim,
    input  logic          strap_ratio_hi,
    input  logic          setup_ilim_ovr,
    input  logic [IW-1:0] setup_ilim,
    input  logic          setup_ratio_ovr,
    input  logic          setup_ratio_hi,
    output logic [IW-1:0] eff_ilim,
    output logic          eff_ratio_hi
);

    always_comb begin
        eff_ilim     = setup_ilim_ovr  ? setup_ilim     : strap_ilim;
        eff_ratio_hi = setup_ratio_ovr ? setup_ratio_hi : strap_ratio_hi;
    end

endmodule

// File: rtl/hsw_compare.sv
module hsw_compare
    import hsw_pkg::*;
#(
    parameter int IW = 12,
    parameter int VW = 12
) (
    input  logic [IW-1:0]    i_meas,
    input  logic [VW-1:0]    v_ds,
    input  logic [IW-1:0]    eff_ilim,
    input  logic             eff_ratio_hi,
    input  logic [IW+VW-1:0] pwr_lim,
    output logic             ilim_hit,
    output logic             plim_hit,
    output logic             cb_hit
);

    localparam int XW = IW + TRIP_GUARD;
    localparam int PW = IW + VW;

    logic [XW-1:0] cur_scaled;
    logic [XW-1:0] lvl_low;
    logic [XW-1:0] lvl_sel;
    logic [PW-1:0] pwr_now;

    always_comb begin
        cur_scaled = XW'(i_meas) * XW'(TRIP_DEN);
        lvl_low    = XW'(eff_ilim) * XW'(TRIP_NUM);
        lvl_sel    = eff_ratio_hi ? (lvl_low << 1) : lvl_low;
        pwr_now    = PW'(i_meas) * PW'(v_ds);

        ilim_hit   = (i_meas >= eff_ilim);
        plim_hit   = (pwr_now >= pwr_lim);
        cb_hit     = (cur_scaled > lvl_sel);
    end

endmodule

// File: rtl/hsw_trip_fsm.sv
module hsw_trip_fsm
    import hsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic ilim_hit,
    input  logic plim_hit,
    input  logic cb_hit,
    output logic limit_active,
    output logic gate_pulldown,
    output logic ilim_active,
    output logic plim_active
);

    lim_state_e state_q;
    lim_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_NORMAL, ST_LIMIT: begin
                if (cb_hit)
                    state_n = ST_TRIP;            // T_BREAK
                else if (ilim_hit || plim_hit)
                    state_n = ST_LIMIT;           // T_ENGAGE / stay
                else
                    state_n = ST_NORMAL;          // T_DISENGAGE / stay
            end
            ST_TRIP: begin
                if (!ilim_hit)
                    state_n = plim_hit ? ST_LIMIT // T_RELEASE_LIMIT
                                       : ST_NORMAL; // T_RELEASE_IDLE
                else
                    state_n = ST_TRIP;
            end
            default: state_n = ST_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_NORMAL;
        else if (smp_valid)
            state_q <= state_n;
    end

    // Registered outputs, updated together with the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_active  <= 1'b0;
            gate_pulldown <= 1'b0;
            ilim_active   <= 1'b0;
            plim_active   <= 1'b0;
        end else if (smp_valid) begin
            limit_active  <= (state_n != ST_NORMAL);
            gate_pulldown <= (state_n == ST_TRIP);
            ilim_active   <= ilim_hit;
            plim_active   <= plim_hit;
        end
    end

endmodule

// File: rtl/hsw_status.sv
module hsw_status #(
    parameter int NB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_vec,
    input  logic          clr,
    input  logic [NB-1:0] mask,
    output logic [NB-1:0] status,
    output logic          alert
);

    logic [NB-1:0] keep;

    always_comb keep = clr ? '0 : status;

    // Set takes priority over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status <= '0;
        else
            status <= keep | set_vec;
    end

    always_comb alert = |(status & ~mask);

endmodule

// File: rtl/hsw_limit_detect.sv
module hsw_limit_detect
    import hsw_pkg::*;
#(
    parameter int IW = 12,
    parameter int VW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [IW-1:0]    i_meas,
    input  logic [VW-1:0]    v_ds,
    input  logic [IW-1:0]    strap_ilim,
    input  logic             strap_ratio_hi,
    input  logic             setup_ilim_ovr,
    input  logic [IW-1:0]    setup_ilim,
    input  logic             setup_ratio_ovr,
    input  logic             setup_ratio_hi,
    input  logic [IW+VW-1:0] pwr_lim,
    input  logic [2:0]       alert_mask,
    input  logic             status_clr,
    output logic             limit_active,
    output logic             gate_pulldown,
    output logic             ilim_active,
    output logic             plim_active,
    output logic [2:0]       status,
    output logic             alert
);

    logic [IW-1:0]      eff_ilim;
    logic               eff_ratio_hi;
    logic               ilim_hit;
    logic               plim_hit;
    logic               cb_hit;
    logic [NUM_EVT-1:0] evt_set;

    hsw_cfg_sel #(.IW(IW)) u_cfg (
        .strap_ilim     (strap_ilim),
        .strap_ratio_hi (strap_ratio_hi),
        .setup_ilim_ovr (setup_ilim_ovr),
        .setup_ilim     (setup_ilim),
        .setup_ratio_ovr(setup_ratio_ovr),
        .setup_ratio_hi (setup_ratio_hi),
        .eff_ilim       (eff_ilim),
        .eff_ratio_hi   (eff_ratio_hi)
    );

    hsw_compare #(.IW(IW), .VW(VW)) u_cmp (
        .i_meas      (i_meas),
        .v_ds        (v_ds),
        .eff_ilim    (eff_ilim),
        .eff_ratio_hi(eff_ratio_hi),
        .pwr_lim     (pwr_lim),
        .ilim_hit    (ilim_hit),
        .plim_hit    (plim_hit),
        .cb_hit      (cb_hit)
    );

    hsw_trip_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .ilim_hit     (ilim_hit),
        .plim_hit     (plim_hit),
        .cb_hit       (cb_hit),
        .limit_active (limit_active),
        .gate_pulldown(gate_pulldown),
        .ilim_active  (ilim_active),
        .plim_active  (plim_active)
    );

    always_comb begin
        evt_set           = '0;
        evt_set[EVT_ILIM] = smp_valid & ilim_hit;
        evt_set[EVT_PLIM] = smp_valid & plim_hit;
        evt_set[EVT_TRIP] = smp_valid & cb_hit;
    end

    hsw_status #(.NB(NUM_EVT)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(evt_set),
        .clr    (status_clr),
        .mask   (alert_mask),
        .status (status),
        .alert  (alert)
    );

endmodule

// File: rtl/hsw_limit_chk.sv
module hsw_limit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic       status_clr,
    input logic       limit_active,
    input logic       gate_pulldown,
    input logic       ilim_active,
    input logic       plim_active,
    input logic [2:0] status,
    input logic       alert
);

    assert_pulldown_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pulldown |-> limit_active);

    assert_limit_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_active && !gate_pulldown) |-> (ilim_active || plim_active));

    assert_trip_hyst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pulldown |-> ilim_active);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable({limit_active, gate_pulldown, ilim_active, plim_active}));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clr |=> ((status & $past(status)) == $past(status)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr && !smp_valid) |=> (status == 3'b000));

    assert_alert_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alert |-> (status != 3'b000));

    assert_trip_logged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_pulldown) |-> status[2]);

endmodule

bind hsw_limit_detect hsw_limit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .status_clr   (status_clr),
    .limit_active (limit_active),
    .gate_pulldown(gate_pulldown),
    .ilim_active  (ilim_active),
    .plim_active  (plim_active),
    .status       (status),
    .alert        (alert)
);

// File: tb/sim_hsw_limit_detect.sv
`timescale 1ns/1ps
module sim_hsw_limit_detect;

    localparam int IW = 12;
    localparam int VW = 12;
    localparam int NV = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_valid = 1'b0;
    logic [IW-1:0]    i_meas = '0;
    logic [VW-1:0]    v_ds = '0;
    logic [IW-1:0]    strap_ilim = 12'd100;
    logic             strap_ratio_hi = 1'b0;
    logic             setup_ilim_ovr = 1'b0;
    logic [IW-1:0]    setup_ilim = '0;
    logic             setup_ratio_ovr = 1'b0;
    logic             setup_ratio_hi = 1'b0;
    logic [IW+VW-1:0] pwr_lim = 24'hFFFFFF;
    logic [2:0]       alert_mask = 3'b000;
    logic             status_clr = 1'b0;
    logic             limit_active, gate_pulldown, ilim_active, plim_active, alert;
    logic [2:0]       status;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    hsw_limit_detect #(.IW(IW), .VW(VW)) u0 (.*);

    // {i, v, ilim, ratio_hi, pwr, expected {gate, limit, plim, ilim}}
    localparam logic [64:0] TBL [NV] = '{
        {12'd50,  12'd0,   12'd100, 1'b0, 24'hFFFFFF, 4'b0000},
        {12'd100, 12'd0,   12'd100, 1'b0, 24'hFFFFFF, 4'b0101},
        {12'd180, 12'd0,   12'd100, 1'b0, 24'hFFFFFF, 4'b0101},
        {12'd181, 12'd0,   12'd100, 1'b0, 24'hFFFFFF, 4'b1101},
        {12'd181, 12'd0,   12'd100, 1'b1, 24'hFFFFFF, 4'b0101},
        {12'd361, 12'd0,   12'd100, 1'b1, 24'hFFFFFF, 4'b1101},
        {12'd50,  12'd100, 12'd100, 1'b0, 24'd5000,   4'b0110},
        {12'd50,  12'd99,  12'd100, 1'b0, 24'd5000,   4'b0000},
        {12'd0,   12'd0,   12'd0,   1'b0, 24'hFFFFFF, 4'b0101}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample(input logic [IW-1:0] i, input logic [VW-1:0] v);
        @(negedge clk);
        i_meas = i; v_ds = v; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    function automatic logic [3:0] flags();
        return {gate_pulldown, limit_active, plim_active, ilim_active};
    endfunction

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags after reset", 32'(flags()), 32'h0);
        chk("R1 status after reset", 32'(status), 32'h0);
        chk("R1 alert after reset", 32'(alert), 32'h0);
        rst_n = 1'b1;

        // Table: each row starts from ST_NORMAL (settle sample first)
        for (int k = 0; k < NV; k++) begin
            strap_ilim = 12'd100; strap_ratio_hi = 1'b0; pwr_lim = 24'hFFFFFF;
            sample(12'd0, 12'd0);
            strap_ilim     = TBL[k][40:29];
            strap_ratio_hi = TBL[k][28];
            pwr_lim        = TBL[k][27:4];
            sample(TBL[k][64:53], TBL[k][52:41]);
            chk($sformatf("R2 R3 R4 R6 vector %0d", k), 32'(flags()), 32'(TBL[k][3:0]));
        end

        // R5 hysteresis and release paths
        strap_ilim = 12'd100; strap_ratio_hi = 1'b0; pwr_lim = 24'd5000;
        sample(12'd0, 12'd0);
        sample(12'd200, 12'd0);
        chk("R4 trip at 2x", 32'(flags()), 32'b1101);
        sample(12'd150, 12'd0);
        chk("R5 trip held above limit", 32'(flags()), 32'b1101);
        sample(12'd99, 12'd100);
        chk("R5 release to limit by power", 32'(flags()), 32'b0110);
        sample(12'd99, 12'd0);
        chk("R6 back to normal", 32'(flags()), 32'b0000);

        // R10 idle edges ignored
        @(negedge clk);
        i_meas = 12'd300; v_ds = 12'd300;
        repeat (3) @(negedge clk);
        chk("R10 no sample no change", 32'(flags()), 32'b0000);

        // R7 overrides
        pwr_lim = 24'hFFFFFF; setup_ilim = 12'd50; setup_ilim_ovr = 1'b1;
        sample(12'd60, 12'd0);
        chk("R7 ilim override used", 32'(flags()), 32'b0101);
        setup_ilim_ovr = 1'b0;
        sample(12'd60, 12'd0);
        chk("R7 strap ilim used", 32'(flags()), 32'b0000);
        setup_ratio_ovr = 1'b1; setup_ratio_hi = 1'b1;
        sample(12'd181, 12'd0);
        chk("R7 ratio override 3.6x", 32'(flags()), 32'b0101);
        setup_ratio_ovr = 1'b0;
        sample(12'd0, 12'd0);
        sample(12'd181, 12'd0);
        chk("R7 strap ratio 1.8x", 32'(flags()), 32'b1101);
        sample(12'd0, 12'd0);

        // R8 / R9 status and alert
        chk("R8 sticky after activity", 32'(status), 32'b111);
        clr_pulse();
        chk("R8 cleared", 32'(status), 32'b000);
        chk("R9 alert low when clear", 32'(alert), 32'h0);
        pwr_lim = 24'd5000;
        sample(12'd50, 12'd100);
        sample(12'd0, 12'd0);
        chk("R8 power bit only", 32'(status), 32'b010);
        chk("R9 alert unmasked", 32'(alert), 32'h1);
        @(negedge clk); alert_mask = 3'b010;
        @(negedge clk);
        chk("R9 alert masked", 32'(alert), 32'h0);
        chk("R9 masked bit kept", 32'(status), 32'b010);
        alert_mask = 3'b000;
        clr_pulse();
        pwr_lim = 24'hFFFFFF;
        @(negedge clk);
        i_meas = 12'd200; v_ds = 12'd0; smp_valid = 1'b1; status_clr = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; status_clr = 1'b0;
        chk("R8 set wins over clear", 32'(status), 32'b101);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule